// File: doc/BRIEF.md
# Scaled Raster Timing and Frame Buffer Address Generator

This block runs the beam position for a 640x480, 60 Hz display from a single pixel clock. A horizontal counter walks every pixel slot of a line, including blanking. A vertical counter advances once per line. From these two counts the block derives the horizontal and vertical sync pulses and a data-enable flag.

In the same cycle it works out which byte of a 320x200, one-byte-per-pixel frame buffer feeds the current display position. Horizontally each source pixel is shown twice, so the source column is the display column with its lowest bit discarded. Vertically the 2.4 stretch is approximated by a constant multiply followed by a right shift. The byte address is row × 320 + column.

The address leaves the block in the same cycle as its counter position. Sync and data enable are held back by a fixed number of cycles (parameter `LAT`, default 2). That delay covers the frame buffer read and the palette lookup, so the control signals arrive together with the colour data of the same pixel.

Top module: `vid_raster_addr`

## Requirements
- R1: A line lasts 800 cycles. Consecutive falling edges of `hsync_n` are exactly 800 cycles apart.
- R2: `hsync_n` is active-low. It is 0 for exactly 96 cycles in each line and 1 otherwise. For a horizontal count of x, the pulse covers 656 ≤ x < 752. The pulse follows the line's first pixel by 656 cycles.
- R3: A frame lasts 525 lines. Consecutive falling edges of `vsync_n` are 525 × 800 cycles apart.
- R4: `vsync_n` is active-low. It is 0 throughout lines 490 and 491 and 1 on all other lines, so each pulse lasts 2 full lines.
- R5: `de` is 1 exactly when the horizontal count is below 640 and the vertical count is below 480. It is 1 for 640 cycles of every active line and never while either sync is 0.
- R6: Inside the active region, `rd_addr` = ((y × 1705) >> 12) × 320 + (x >> 1) for display position (x, y). It shows the position's address in the same cycle as the counters. Line 479 maps to source row 199, and the largest address is 63999.
- R7: Outside the active region, `rd_addr` is 0.
- R8: `hsync_n`, `vsync_n` and `de` for a position appear `LAT` cycles (default 2) after that position's `rd_addr`.
- R9: A synchronous `rst` sets both counters to position (0,0). While reset is applied, `de` is 0, both syncs are 1 and `rd_addr` is 0. The first cycle after release presents the address of pixel (0,0), and `de` first rises `LAT` cycles after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Horizontal sync, active low, delayed by LAT |
| vsync_n | output | 1 | Vertical sync, active low, delayed by LAT |
| de | output | 1 | Data enable, delayed by LAT |
| rd_addr | output | ADDR_W (16) | Frame buffer byte address for the current position, 0 in blanking |

## Verification
The default-geometry instance is followed through its first lines. This shows whether the edges of the horizontal sync pulse are placed correctly and whether the line length is right. It also shows whether rows with fractional scale steps (lines 3 and 5) pick the right source row. A second instance keeps the full vertical geometry but has a very short line, so whole frames complete quickly. That instance brings out the vertical sync lines, the frame length, the row-199 end of the mapping and the zero address in vertical blanking. A reset applied mid-frame shows that the counters and the delayed control signals restart together rather than continuing from stale state.

// File: rtl/raster_pkg.sv
package raster_pkg;
   typedef struct packed {
      logic hs_n;
      logic vs_n;
      logic de;
   } vid_ctl_t;

   localparam vid_ctl_t CTL_IDLE = '{hs_n: 1'b1, vs_n: 1'b1, de: 1'b0};
endpackage

// File: rtl/raster_axis_cnt.sv
module raster_axis_cnt #(
   parameter int TOTAL = 800,
   parameter int W     = $clog2(TOTAL)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] LAST = W'(TOTAL - 1);

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (adv)
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/raster_axis_decode.sv
module raster_axis_decode #(
   parameter int ACT = 640,
   parameter int FP  = 16,
   parameter int SP  = 96,
   parameter int W   = 10
) (
   input  logic [W-1:0] cnt,
   output logic         active,
   output logic         in_sync
);
   localparam logic [W-1:0] SYNC_LO = W'(ACT + FP);
   localparam logic [W-1:0] SYNC_HI = W'(ACT + FP + SP);

   assign active  = (cnt < W'(ACT));
   assign in_sync = (cnt >= SYNC_LO) && (cnt < SYNC_HI);
endmodule

// File: rtl/raster_src_map.sv
module raster_src_map #(
   parameter int SRC_W   = 320,
   parameter int Y_MUL   = 1705,
   parameter int Y_SHIFT = 12,
   parameter int HC_W    = 10,
   parameter int VC_W    = 10,
   parameter int ADDR_W  = 16
) (
   input  logic [HC_W-1:0]   x,
   input  logic [VC_W-1:0]   y,
   input  logic              active,
   output logic [ADDR_W-1:0] addr
);
   localparam int MUL_W  = $clog2(Y_MUL + 1);
   localparam int PROD_W = VC_W + MUL_W;

   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] row_idx;
   logic [ADDR_W-1:0] row_base;
   logic [ADDR_W-1:0] col;

   assign prod    = PROD_W'(y) * PROD_W'(Y_MUL);
   assign row_idx = prod >> Y_SHIFT;
   assign col     = ADDR_W'(x >> 1);

   generate
      if (SRC_W == 320) begin : g_shift_add
         assign row_base = ADDR_W'((row_idx << 8) + (row_idx << 6));
      end else begin : g_mult
         assign row_base = ADDR_W'(row_idx * PROD_W'(SRC_W));
      end
   endgenerate

   assign addr = active ? (row_base + col) : '0;
endmodule

// File: rtl/raster_ctl_delay.sv
module raster_ctl_delay
   import raster_pkg::*;
#(
   parameter int LAT = 2
) (
   input  logic     clk,
   input  logic     rst,
   input  vid_ctl_t d,
   output vid_ctl_t q
);
   generate
      if (LAT == 0) begin : g_bypass
         assign q = d;
      end else begin : g_pipe
         vid_ctl_t stg [LAT];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < LAT; i++) stg[i] <= CTL_IDLE;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[LAT-1];
      end
   endgenerate
endmodule

// File: rtl/vid_raster_addr.sv
module vid_raster_addr
   import raster_pkg::*;
#(
   parameter int H_ACT   = 640,
   parameter int H_FP    = 16,
   parameter int H_SP    = 96,
   parameter int H_BP    = 48,
   parameter int V_ACT   = 480,
   parameter int V_FP    = 10,
   parameter int V_SP    = 2,
   parameter int V_BP    = 33,
   parameter int SRC_W   = 320,
   parameter int SRC_H   = 200,
   parameter int Y_MUL   = 1705,
   parameter int Y_SHIFT = 12,
   parameter int ADDR_W  = 16,
   parameter int LAT     = 2
) (
   input  logic              clk,
   input  logic              rst,
   output logic              hsync_n,
   output logic              vsync_n,
   output logic              de,
   output logic [ADDR_W-1:0] rd_addr
);
   localparam int H_TOT = H_ACT + H_FP + H_SP + H_BP;
   localparam int V_TOT = V_ACT + V_FP + V_SP + V_BP;
   localparam int HC_W  = $clog2(H_TOT);
   localparam int VC_W  = $clog2(V_TOT);

   generate
      if (H_BP < 1 || V_BP < 1) begin : g_bad_porch
         $error("back porch must be at least one count on both axes");
      end
      if (LAT < 0) begin : g_bad_lat
         $error("LAT must not be negative");
      end
      if (ADDR_W < $clog2(SRC_W * SRC_H)) begin : g_bad_addr
         $error("ADDR_W too narrow for the source image");
      end
      if ((((V_ACT - 1) * Y_MUL) >> Y_SHIFT) > SRC_H - 1) begin : g_bad_vscale
         $error("vertical scale overruns the source height");
      end
      if ((H_ACT / 2) > SRC_W) begin : g_bad_hscale
         $error("horizontal scale overruns the source width");
      end
   endgenerate

   logic [HC_W-1:0] x_cnt;
   logic [VC_W-1:0] y_cnt;
   logic            line_end;
   logic            h_act, h_sync, v_act, v_sync;
   vid_ctl_t        ctl_now, ctl_out;

   assign line_end = (x_cnt == HC_W'(H_TOT - 1));

   raster_axis_cnt #(.TOTAL(H_TOT), .W(HC_W)) u_hcnt (
      .clk(clk), .rst(rst), .adv(1'b1), .cnt(x_cnt)
   );

   raster_axis_cnt #(.TOTAL(V_TOT), .W(VC_W)) u_vcnt (
      .clk(clk), .rst(rst), .adv(line_end), .cnt(y_cnt)
   );

   raster_axis_decode #(.ACT(H_ACT), .FP(H_FP), .SP(H_SP), .W(HC_W)) u_hdec (
      .cnt(x_cnt), .active(h_act), .in_sync(h_sync)
   );

   raster_axis_decode #(.ACT(V_ACT), .FP(V_FP), .SP(V_SP), .W(VC_W)) u_vdec (
      .cnt(y_cnt), .active(v_act), .in_sync(v_sync)
   );

   raster_src_map #(
      .SRC_W(SRC_W), .Y_MUL(Y_MUL), .Y_SHIFT(Y_SHIFT),
      .HC_W(HC_W), .VC_W(VC_W), .ADDR_W(ADDR_W)
   ) u_map (
      .x(x_cnt), .y(y_cnt), .active(h_act && v_act), .addr(rd_addr)
   );

   assign ctl_now = '{hs_n: ~h_sync, vs_n: ~v_sync, de: h_act && v_act};

   raster_ctl_delay #(.LAT(LAT)) u_dly (
      .clk(clk), .rst(rst), .d(ctl_now), .q(ctl_out)
   );

   assign hsync_n = ctl_out.hs_n;
   assign vsync_n = ctl_out.vs_n;
   assign de      = ctl_out.de;
endmodule

// File: rtl/vid_raster_chk.sv
module vid_raster_chk #(
   parameter int H_TOT    = 800,
   parameter int H_SP     = 96,
   parameter int FRAME    = 420000,
   parameter int ADDR_W   = 16,
   parameter int ADDR_LIM = 64000
) (
   input logic              clk,
   input logic              rst,
   input logic              hsync_n,
   input logic              vsync_n,
   input logic              de,
   input logic [ADDR_W-1:0] rd_addr
);
   logic rst_q = 1'b0;
   logic hs_q, vs_q, seen_h, seen_v;
   int   hcnt, lcnt, fcnt;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst) begin
         hs_q <= 1'b1; vs_q <= 1'b1;
         seen_h <= 1'b0; seen_v <= 1'b0;
         hcnt <= 0; lcnt <= 0; fcnt <= 0;
      end else begin
         hs_q <= hsync_n;
         vs_q <= vsync_n;
         if (hs_q && !hsync_n) begin hcnt <= 0; seen_h <= 1'b1; end
         else hcnt <= hcnt + 1;
         if (!hsync_n) lcnt <= lcnt + 1;
         else lcnt <= 0;
         if (vs_q && !vsync_n) begin fcnt <= 0; seen_v <= 1'b1; end
         else fcnt <= fcnt + 1;
      end
   end

   assert_line_len_R1: assert property (@(posedge clk) disable iff (rst)
      (seen_h && hs_q && !hsync_n) |-> (hcnt == H_TOT - 1));

   assert_hs_width_R2: assert property (@(posedge clk) disable iff (rst)
      (!hs_q && hsync_n) |-> (lcnt == H_SP));

   assert_frame_len_R3: assert property (@(posedge clk) disable iff (rst)
      (seen_v && vs_q && !vsync_n) |-> (fcnt == FRAME - 1));

   assert_de_sync_R5: assert property (@(posedge clk) disable iff (rst)
      de |-> (hsync_n && vsync_n));

   assert_addr_lim_R6: assert property (@(posedge clk) disable iff (rst)
      rd_addr < ADDR_W'(ADDR_LIM));

   assert_reset_R9: assert property (@(posedge clk) disable iff (rst)
      rst_q |-> (!de && hsync_n && vsync_n && rd_addr == '0));
endmodule

bind vid_raster_addr vid_raster_chk #(
   .H_TOT(H_TOT), .H_SP(H_SP), .FRAME(H_TOT * V_TOT),
   .ADDR_W(ADDR_W), .ADDR_LIM(SRC_W * SRC_H)
) u_chk (
   .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
   .de(de), .rd_addr(rd_addr)
);

// File: tb/sim_vid_raster_addr.sv
`timescale 1ns/1ps
module sim_vid_raster_addr;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic hs0, vs0, de0, hs1, vs1, de1;
   logic [15:0] a0, a1;
   int c = 0;
   int nvec = 0;
   int nbad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   vid_raster_addr u0 (
      .clk(clk), .rst(rst), .hsync_n(hs0), .vsync_n(vs0), .de(de0), .rd_addr(a0)
   );

   vid_raster_addr #(.H_ACT(8), .H_FP(1), .H_SP(2), .H_BP(1)) u1 (
      .clk(clk), .rst(rst), .hsync_n(hs1), .vsync_n(vs1), .de(de1), .rd_addr(a1)
   );

   function automatic logic [18:0] model(int cyc, int ha, int hf, int hs, int hb,
                                          int va, int vf, int vs, int vb);
      int ht, vt, p, x, y, q, xq, yq, addr;
      logic h_n, v_n, d;
      ht = ha + hf + hs + hb;
      vt = va + vf + vs + vb;
      p = cyc % (ht * vt);
      x = p % ht; y = p / ht;
      addr = (x < ha && y < va) ? (((y * 1705) >> 12) * 320 + x / 2) : 0;
      q = cyc - 2;
      if (q < 0) begin
         h_n = 1'b1; v_n = 1'b1; d = 1'b0;
      end else begin
         q = q % (ht * vt);
         xq = q % ht; yq = q / ht;
         d   = (xq < ha && yq < va);
         h_n = !(xq >= ha + hf && xq < ha + hf + hs);
         v_n = !(yq >= va + vf && yq < va + vf + vs);
      end
      return {h_n, v_n, d, addr[15:0]};
   endfunction

   task automatic cmp(string tag, int act, int exp);
      nvec++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, c);
      end
   endtask

   task automatic chk_one(string who, logic [18:0] act, logic [18:0] exp);
      cmp({"R2 hsync ", who}, int'(act[18]), int'(exp[18]));
      cmp({"R4 vsync ", who}, int'(act[17]), int'(exp[17]));
      cmp({"R5 de ", who}, int'(act[16]), int'(exp[16]));
      cmp({"R6 or R7 addr ", who}, int'(act[15:0]), int'(exp[15:0]));
   endtask

   task automatic step();
      @(negedge clk);
      c++;
      chk_one("u0", {hs0, vs0, de0, a0}, model(c, 640, 16, 96, 48, 480, 10, 2, 33));
      chk_one("u1", {hs1, vs1, de1, a1}, model(c, 8, 1, 2, 1, 480, 10, 2, 33));
   endtask

   task automatic wait_c(int target);
      while (c < target) step();
   endtask

   // R9 and R8: state at release and the LAT-cycle lag of de
   task automatic t_reset();
      cmp("R9 de at release", int'(de0), 0);
      cmp("R9 hsync at release", int'(hs0), 1);
      cmp("R9 vsync at release", int'(vs0), 1);
      cmp("R9 addr at release", int'(a0), 0);
      cmp("R9 u1 de at release", int'(de1), 0);
      step();
      cmp("R8 de still low one cycle after release", int'(de0), 0);
      step();
      cmp("R8 de high LAT cycles after release", int'(de0), 1);
      cmp("R6 addr of pixel 2", int'(a0), 1);
      cmp("R8 u1 de high LAT cycles after release", int'(de1), 1);
   endtask

   // R1, R2, R5 on the default geometry
   task automatic t_line();
      int t0, n;
      while (hs0) step();
      cmp("R2 hsync fall position", c, 658);
      t0 = c;
      while (!hs0) step();
      cmp("R2 hsync low width", c - t0, 96);
      while (hs0) step();
      cmp("R1 line length", c - t0, 800);
      n = 0;
      for (int i = 0; i < 800; i++) begin
         step();
         n += int'(de0);
      end
      cmp("R5 de cycles per active line", n, 640);
   endtask

   // R6, R7 on rows with fractional scale steps
   task automatic t_addr_rows();
      wait_c(2400);
      cmp("R6 line 3 first pixel", int'(a0), 320);
      wait_c(3039);
      cmp("R6 line 3 last pixel", int'(a0), 639);
      wait_c(3040);
      cmp("R7 line 3 first blank slot", int'(a0), 0);
      wait_c(4100);
      cmp("R6 line 5 column 100", int'(a0), 690);
   endtask

   // R6, R7 at the bottom of the picture (short-line instance)
   task automatic t_last_line();
      wait_c(5755);
      cmp("R6 line 479 last pixel maps to row 199", int'(a1), 63683);
      wait_c(5760);
      cmp("R7 vertical blanking address", int'(a1), 0);
   endtask

   // R3, R4 on the short-line instance
   task automatic t_frame();
      int t0;
      while (vs1) step();
      cmp("R4 vsync fall position", c, 5882);
      t0 = c;
      while (!vs1) step();
      cmp("R4 vsync low width", c - t0, 24);
      while (vs1) step();
      cmp("R3 frame length", c - t0, 6300);
   endtask

   // R9 mid-frame
   task automatic t_mid_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      cmp("R9 de during reset", int'(de0), 0);
      cmp("R9 hsync during reset", int'(hs1), 1);
      cmp("R9 vsync during reset", int'(vs1), 1);
      cmp("R9 addr during reset", int'(a0), 0);
      rst = 1'b0;
      c = 0;
      t_reset();
      wait_c(3000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      c = 0;
      t_reset();
      t_line();
      t_addr_rows();
      t_last_line();
      t_frame();
      wait_c(40000);
      t_mid_reset();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         nbad++;
         $display("FAIL watchdog R1: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end
endmodule